// File: doc/BRIEF.md
# Encoder Test-Mode Stimulus Controller

This block holds the test features of an optical position encoder's digital core. A test-enable pin turns test operation on, and a mode pin picks one of two test modes. In the analog test mode, a five-bit track-select mask is loaded serially. The serial output then carries the XOR of the comparator bits of every selected track, so the switching threshold of each track sensor can be probed on its own or in combination with others.

In the digital test mode, serial data is routed through a five-bit stimulus register before it reaches the downstream output shift register. When the serial clock has stayed quiet for a programmable number of system-clock cycles, the next falling serial-clock edge latches the stimulus word. From then on, that word replaces the live comparator values that feed the rest of the core. Sensor inputs can therefore be emulated without any light source.

In either test mode, the error pin is turned into a push-pull output that carries the XOR of the seven interface inputs, which allows their input thresholds to be measured. The serial clock is sampled on the system clock. An edge is a change between two consecutive samples.

Top module: `enc_tm_ctrl`

## Requirements
- R1: After reset the track-select mask is zero, no stimulus is applied (`track_eff` equals `track_live`), `sout` is 0, `err_oe` is 0 and `err_out` is 1.
- R2: `test_en`=1 with `mode_dig`=1 selects digital test, and `test_en`=1 with `mode_dig`=0 selects analog test. With `test_en`=0, `sout` is 0, `ser_fwd` equals `sdata` and `track_eff` equals `track_live`.
- R3: In analog test, each falling edge of `ser_clk` shifts the mask left and takes `sdata` into bit 0, so the first of five bits sent lands in bit 4. Mask bit i selects track i.
- R4: In analog test, `sout` is the XOR of `track_live[i]` over every i whose mask bit is 1, and 0 when no bit is set.
- R5: The mask is cleared in every cycle in which analog test is not active.
- R6: In digital test, each falling edge of `ser_clk` shifts the stimulus register the same way as R3, and `ser_fwd` carries its bit 4.
- R7: An idle counter counts system-clock cycles since the last `ser_clk` edge, saturating at `IDLE_CYC`. A falling edge that arrives while the count equals `IDLE_CYC` latches the stimulus word as it stood before that edge's shift. This happens after `IDLE_CYC` quiet cycles but not after `IDLE_CYC`-1. The latched word drives `track_eff` until the next latch.
- R8: When `op_mode` is 2'b00 (unsynchronized binary), a latch event selects the live values, so `track_eff` follows `track_live`.
- R9: With `test_en`=1, `err_oe` is 1 and `err_out` is the XOR of `cal_ref`, `cal_trk`, `sdata`, `ser_clk`, `dir_n`, `inv_n` and `edge_sel`. With `test_en`=0, `err_oe` is 0 and `err_out` is 1.
- R10: Leaving digital test drops any latched stimulus: `track_eff` follows `track_live` at once, and it still does after digital test is entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | Test operation enable |
| mode_dig | input | 1 | 1 selects digital test, 0 selects analog test |
| op_mode | input | 2 | Serial operating mode; 2'b00 is unsynchronized binary |
| ser_clk | input | 1 | Serial clock, idle high, active on falling edges |
| sdata | input | 1 | Serial data input |
| cal_ref | input | 1 | Reference test-current pin level |
| cal_trk | input | 1 | Track test-current pin level |
| dir_n | input | 1 | Count-direction pin |
| inv_n | input | 1 | Code-inversion pin |
| edge_sel | input | 1 | Synchronization edge-select pin |
| track_live | input | 5 | Live track comparator bits |
| track_eff | output | 5 | Track values passed to the core |
| sout | output | 1 | Selected-track XOR output |
| ser_fwd | output | 1 | Data forwarded to the output shift register |
| err_out | output | 1 | Error pin level |
| err_oe | output | 1 | Error pin push-pull drive enable |

## Verification
The assertions assume that every input is synchronous to `clk` and that `ser_clk` holds each level for at least one system-clock cycle, so each serial-clock transition is seen as exactly one edge. The stimulus changes every input half a clock period away from the active edge and holds each `ser_clk` level for one or more full cycles. The idle windows are counted in whole system-clock cycles after the rising edge that restarts the counter, which puts the latch decision exactly on either side of the threshold.

// File: rtl/enc_tm_pkg.sv
package enc_tm_pkg;

    localparam int TRK_W = 5;

    typedef enum logic [1:0] {
        OPM_NOSYNC_BIN  = 2'b00,
        OPM_NOSYNC_GRAY = 2'b01,
        OPM_SYNC_LEAD   = 2'b10,
        OPM_SYNC_TRAIL  = 2'b11
    } opm_e;

    typedef enum logic [1:0] {
        TM_OFF     = 2'b00,
        TM_ANALOG  = 2'b01,
        TM_DIGITAL = 2'b10
    } tm_e;

    function automatic tm_e tm_decode(input logic en, input logic dig);
        if (!en)
            return TM_OFF;
        else if (dig)
            return TM_DIGITAL;
        else
            return TM_ANALOG;
    endfunction

endpackage

// File: rtl/enc_tm_edge.sv
module enc_tm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_s;

    edge_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{prev: 1'b1};
        else
            st_q <= st_d;
    end

    assign fall = st_q.prev & ~lvl;
    assign rise = ~st_q.prev & lvl;

endmodule

// File: rtl/enc_tm_idle.sv
module enc_tm_idle #(
    parameter int IDLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_any,
    output logic idle
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(IDLE_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } idle_s;

    idle_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_any)
            st_d.cnt = '0;
        else if (st_q.cnt != LIM)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{cnt: '0};
        else
            st_q <= st_d;
    end

    assign idle = (st_q.cnt == LIM);

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIM);

    assert_edge_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_any |=> !idle);

endmodule

// File: rtl/enc_tm_shreg.sv
module enc_tm_shreg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } sh_s;

    sh_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.bits = '0;
        else if (shift)
            st_d.bits = {st_q.bits[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{bits: '0};
        else
            st_q <= st_d;
    end

    assign q = st_q.bits;

    assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr) |=> (q[0] == $past(din)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

endmodule

// File: rtl/enc_tm_ctrl.sv
module enc_tm_ctrl
    import enc_tm_pkg::*;
#(
    parameter int IDLE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic             mode_dig,
    input  logic [1:0]       op_mode,
    input  logic             ser_clk,
    input  logic             sdata,
    input  logic             cal_ref,
    input  logic             cal_trk,
    input  logic             dir_n,
    input  logic             inv_n,
    input  logic             edge_sel,
    input  logic [TRK_W-1:0] track_live,
    output logic [TRK_W-1:0] track_eff,
    output logic             sout,
    output logic             ser_fwd,
    output logic             err_out,
    output logic             err_oe
);
    typedef struct packed {
        logic             use_stim;
        logic [TRK_W-1:0] hold;
    } top_s;

    tm_e              tm;
    logic             ana, dig;
    logic             sc_fall, sc_rise, idle, cap;
    logic [TRK_W-1:0] sel_q, stim_q;
    top_s             st_d, st_q;

    assign tm  = tm_decode(test_en, mode_dig);
    assign ana = (tm == TM_ANALOG);
    assign dig = (tm == TM_DIGITAL);

    enc_tm_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (ser_clk),
        .fall (sc_fall),
        .rise (sc_rise)
    );

    enc_tm_idle #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_any(sc_fall | sc_rise),
        .idle    (idle)
    );

    enc_tm_shreg #(.W(TRK_W)) u_sel (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!ana),
        .shift(ana & sc_fall),
        .din  (sdata),
        .q    (sel_q)
    );

    enc_tm_shreg #(.W(TRK_W)) u_stim (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (1'b0),
        .shift(dig & sc_fall),
        .din  (sdata),
        .q    (stim_q)
    );

    assign cap = dig & sc_fall & idle;

    always_comb begin
        st_d = st_q;
        if (!dig) begin
            st_d.use_stim = 1'b0;
        end else if (cap) begin
            st_d.use_stim = (opm_e'(op_mode) != OPM_NOSYNC_BIN);
            st_d.hold     = stim_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{use_stim: 1'b0, hold: '0};
        else
            st_q <= st_d;
    end

    assign track_eff = (dig && st_q.use_stim) ? st_q.hold : track_live;
    assign sout      = ana ? ^(sel_q & track_live) : 1'b0;
    assign ser_fwd   = dig ? stim_q[TRK_W-1] : sdata;
    assign err_out   = test_en ? ^{cal_ref, cal_trk, sdata, ser_clk, dir_n, inv_n, edge_sel} : 1'b1;
    assign err_oe    = test_en;

    assert_nobin_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && op_mode == 2'b00) |=> (track_eff == track_live));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap) |=> $stable(st_q.hold));

    assert_exit_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dig) |=> !st_q.use_stim);

endmodule

// File: tb/enc_tm_ctrl_test.sv
module enc_tm_ctrl_test;
    localparam int IDLE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_en = 1'b0, mode_dig = 1'b1;
    logic [1:0] op_mode = 2'b10;
    logic       ser_clk = 1'b1, sdata = 1'b0;
    logic       cal_ref = 1'b0, cal_trk = 1'b0, dir_n = 1'b0, inv_n = 1'b0, edge_sel = 1'b0;
    logic [4:0] track_live = 5'h15;
    logic [4:0] track_eff;
    logic       sout, ser_fwd, err_out, err_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    enc_tm_ctrl #(.IDLE_CYC(IDLE)) uut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .mode_dig(mode_dig),
        .op_mode(op_mode), .ser_clk(ser_clk), .sdata(sdata),
        .cal_ref(cal_ref), .cal_trk(cal_trk), .dir_n(dir_n), .inv_n(inv_n),
        .edge_sel(edge_sel), .track_live(track_live), .track_eff(track_eff),
        .sout(sout), .ser_fwd(ser_fwd), .err_out(err_out), .err_oe(err_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [4:0] v);
        for (int i = 4; i >= 0; i--) begin
            @(negedge clk);
            sdata   = v[i];
            ser_clk = 1'b0;
            @(negedge clk);
            ser_clk = 1'b1;
            @(posedge clk);
        end
    endtask

    task automatic capture(input int m, input logic [4:0] exp, input string tag);
        repeat (m) @(posedge clk);
        @(negedge clk);
        sdata   = 1'b0;
        ser_clk = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(track_eff == exp, tag, track_eff, exp);
        ser_clk = 1'b1;
        @(posedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [4:0] prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(track_eff == track_live, "R1 track_eff", track_eff, track_live);
        chk(sout == 1'b0, "R1 sout", sout, 0);
        chk(err_oe == 1'b0 && err_out == 1'b1, "R1 err pin", {err_oe, err_out}, 2'b01);
        // R2 test off
        sdata = 1'b1;
        #1;
        chk(ser_fwd == 1'b1, "R2 ser_fwd passthrough", ser_fwd, 1);
        sdata = 1'b0;

        // analog test: R5 cleared on entry, R3/R4 sweep
        @(negedge clk);
        test_en  = 1'b1;
        mode_dig = 1'b0;
        track_live = 5'h1f;
        #1;
        chk(sout == 1'b0, "R5 mask clear on entry", sout, 0);
        for (int s = 0; s < 32; s++) begin
            load(5'(s));
            for (int t = 0; t < 32; t++) begin
                @(negedge clk);
                track_live = 5'(t);
                #1;
                chk(sout == ^(5'(s) & 5'(t)), "R3 R4 selected XOR", sout, ^(5'(s) & 5'(t)));
                if (t == 9)
                    chk(track_eff == track_live, "R2 analog live tracks", track_eff, track_live);
            end
        end
        // R5 clear on leaving analog
        load(5'h01);
        @(negedge clk);
        mode_dig = 1'b1;
        @(negedge clk);
        mode_dig = 1'b0;
        track_live = 5'h1f;
        #1;
        chk(sout == 1'b0, "R5 mask cleared after exit", sout, 0);

        // digital test: R6/R7 sweep
        @(negedge clk);
        mode_dig = 1'b1;
        op_mode  = 2'b10;
        prev = 5'h00;
        for (int v = 0; v < 32; v++) begin
            track_live = ~5'(v);
            load(5'(v));
            #1;
            chk(ser_fwd == v[4], "R6 ser_fwd bit4", ser_fwd, v[4]);
            if (v > 0)
                chk(track_eff == prev, "R7 hold during load", track_eff, prev);
            capture(IDLE, 5'(v), "R7 latch at threshold");
            prev = 5'(v);
        end
        // R7 just below threshold
        load(5'h0a);
        capture(IDLE - 1, 5'h1f, "R7 below threshold no latch");
        load(5'h0a);
        capture(IDLE, 5'h0a, "R7 exact threshold latch");
        load(5'h13);
        capture(IDLE + 3, 5'h13, "R7 beyond threshold latch");

        // R8 unsynchronized binary ignores stimulus
        op_mode = 2'b00;
        track_live = 5'h05;
        load(5'h1c);
        capture(IDLE, 5'h05, "R8 nobin live");
        @(negedge clk);
        track_live = 5'h07;
        #1;
        chk(track_eff == 5'h07, "R8 nobin follows live", track_eff, 5'h07);

        // R10 exit drops stimulus
        op_mode = 2'b10;
        load(5'h11);
        capture(IDLE, 5'h11, "R10 setup latch");
        @(negedge clk);
        test_en = 1'b0;
        #1;
        chk(track_eff == 5'h07, "R10 exit live", track_eff, 5'h07);
        @(negedge clk);
        test_en = 1'b1;
        #1;
        chk(track_eff == 5'h07, "R10 reentry live", track_eff, 5'h07);

        // R9 parity sweep
        for (int p = 0; p < 128; p++) begin
            @(negedge clk);
            {cal_ref, cal_trk, sdata, ser_clk, dir_n, inv_n, edge_sel} = 7'(p);
            #1;
            chk(err_oe == 1'b1 && err_out == ^(7'(p)), "R9 parity", {err_oe, err_out}, {1'b1, ^(7'(p))});
        end
        @(negedge clk);
        test_en = 1'b0;
        {cal_ref, cal_trk, sdata, ser_clk, dir_n, inv_n, edge_sel} = 7'h01;
        #1;
        chk(err_oe == 1'b0 && err_out == 1'b1, "R9 released", {err_oe, err_out}, 2'b01);
        chk(sout == 1'b0, "R2 sout off", sout, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule